// File: doc/BRIEF.md
# Lag-Two Bandpass Recursive Filter Section

This block is a streaming second-order recursive filter for signed audio samples. It has fixed coefficients and gives a bandpass response. For each accepted sample it forms the difference between the current input and the input two samples back. From that difference it subtracts a quarter of the output two samples back. The quarter is taken with a rounding arithmetic shift, so the block uses no multiplier.

The response has zeros at z = +1 and z = -1, so a constant input dies out. The poles at ±0.5j set the peak gain at one quarter of the sample rate. The sum is formed in a widened accumulator with guard bits. It is then clamped to the output width, so an overflow gives the extreme code instead of a wrapped value.

Samples arrive as a valid strobe with data. The result leaves one clock later as a valid strobe with data, one result for each accepted input. Cycles with no input valid leave all filter state untouched.

Top module: `bpf_lag2_section`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and out_data is 0. All four delay taps are cleared, so the first sample accepted after reset comes out unchanged.
- R2: Each clock with in_valid high produces exactly one result, with out_valid high on the next clock. out_valid is low after any clock on which in_valid was low.
- R3: The result is y = x - x2 - ((y2 + 2) >>> 2). Here x2 and y2 are the input and the output from two accepted samples earlier. The rounding shift is to nearest, with ties toward positive.
- R4: Clocks with in_valid low advance no tap, and out_data holds its last value. The next accepted sample computes as if the idle clocks had not happened.
- R5: A sum above 2^(OUT_W-1)-1 gives out_data = 2^(OUT_W-1)-1 (0x7FFF at the default width).
- R6: A sum below -2^(OUT_W-1) gives out_data = -2^(OUT_W-1) (0x8000 at the default width).
- R7: A constant input sequence gives an output that reaches 0 and stays at 0 once the transient has decayed.
- R8: An impulse of amplitude 1024 followed by zeros gives 1024, 0, -1280, 0, 320, 0, -80, 0, 20, 0, -5, 0, 1, 0, 0.
- R9: A settled input of period four samples (A, 0, -A, 0, ...) gives an output amplitude above 2·A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed two's complement input sample |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | OUT_W | Signed saturated result, held between strobes |

## Verification
Every result is due on the clock edge that follows the edge on which its input was accepted. The driver presents a sample at a falling edge and pushes its expected value into a queue. The monitor looks just after each rising edge, so it sees the result of the sample taken on that edge and pops the queue whenever out_valid is set. On idle clocks the bench checks that no result is due and that out_data stays stable. A result with nothing queued, or an item still queued at the end, counts as a miscompare.

// File: rtl/bpf_pkg.sv
// Package: constants shared by the lag-two bandpass section.
// Assumes: the recurrence is fixed, so the shift and rounding offset are constants.
package bpf_pkg;
    // Feedback scale is 1/4, taken as an arithmetic right shift.
    localparam int unsigned FB_SHIFT = 2;
    // Half of the shift step, added before the shift for round-to-nearest.
    localparam int unsigned FB_ROUND = 2;
    // Fewest guard bits that keep x - x2 - y2/4 from wrapping.
    localparam int unsigned MIN_GUARD = 2;

    // Which way the saturator clamped a sum.
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HI   = 2'd1,
        SAT_LO   = 2'd2
    } sat_e;
endpackage

// File: rtl/bpf_tap_line.sv
// Module: a delay line of DEPTH registers, W bits each, that moves only when en is set.
// Assumes: reset is synchronous and active low; only the oldest stage leaves the module.
module bpf_tap_line #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                // Load the newest value into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n)  stage[0] <= '0;
                    else if (en) stage[0] <= d;
                end
            end else begin : g_body
                // Move each older value one stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n)  stage[i] <= '0;
                    else if (en) stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/bpf_fb_scale.sv
// Module: scales a past output by 1/4 with round to nearest (ties toward positive).
// Assumes: ACC_W >= Y_W + 1, so the rounding add and the sign extension fit.
module bpf_fb_scale
    import bpf_pkg::*;
#(
    parameter int unsigned Y_W   = 16,
    parameter int unsigned ACC_W = 18
) (
    input  logic [Y_W-1:0]   y_past,
    output logic [ACC_W-1:0] fb
);
    logic signed [Y_W:0] y_wide;
    logic signed [Y_W:0] y_biased;
    logic signed [Y_W:0] y_shift;

    // Widen by one bit, add the half step, then shift arithmetically.
    always_comb begin
        y_wide   = (Y_W+1)'(signed'(y_past));
        y_biased = y_wide + (Y_W+1)'(FB_ROUND);
        y_shift  = y_biased >>> FB_SHIFT;
        fb       = ACC_W'(y_shift);
    end
endmodule

// File: rtl/bpf_saturate.sv
// Module: clamps a signed accumulator to the signed output range.
// Assumes: ACC_W > OUT_W; the input is two's complement.
module bpf_saturate
    import bpf_pkg::*;
#(
    parameter int unsigned ACC_W = 18,
    parameter int unsigned OUT_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (OUT_W-1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] acc_s;
    sat_e                    kind;

    // Compare against both limits and pick the clamp direction.
    always_comb begin
        acc_s = signed'(acc);
        if (acc_s > MAXV)      kind = SAT_HI;
        else if (acc_s < MINV) kind = SAT_LO;
        else                   kind = SAT_NONE;
    end

    // Select the clamped code or the in-range low bits.
    always_comb begin
        case (kind)
            SAT_HI:  y = {1'b0, {(OUT_W-1){1'b1}}};
            SAT_LO:  y = {1'b1, {(OUT_W-1){1'b0}}};
            default: y = acc[OUT_W-1:0];
        endcase
    end
endmodule

// File: rtl/bpf_lag2_section.sv
// Module: streaming bandpass section, y = x - x(n-2) - round(y(n-2)/4), saturated.
// Assumes: one sample per clock at most; the result is registered, so the feedback
// path always passes through a register; state moves only on in_valid.
module bpf_lag2_section
    import bpf_pkg::*;
#(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned GUARD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int unsigned BASE_W = (IN_W > OUT_W) ? IN_W : OUT_W;
    localparam int unsigned G_USE  = (GUARD < MIN_GUARD) ? MIN_GUARD : GUARD;
    localparam int unsigned ACC_W  = BASE_W + G_USE;
    localparam int unsigned LAG    = 2;

    logic [IN_W-1:0]         x_lag;
    logic [OUT_W-1:0]        y_lag;
    logic [OUT_W-1:0]        y_new;
    logic [ACC_W-1:0]        fb;
    logic signed [ACC_W-1:0] acc;

    bpf_tap_line #(.W(IN_W), .DEPTH(LAG)) u_xline (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(in_data), .q(x_lag)
    );

    bpf_tap_line #(.W(OUT_W), .DEPTH(LAG)) u_yline (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(y_new), .q(y_lag)
    );

    bpf_fb_scale #(.Y_W(OUT_W), .ACC_W(ACC_W)) u_fb (
        .y_past(y_lag), .fb(fb)
    );

    // Form the wide difference with guard bits so that it cannot wrap.
    always_comb begin
        acc = ACC_W'(signed'(in_data)) - ACC_W'(signed'(x_lag)) - signed'(fb);
    end

    bpf_saturate #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sat (
        .acc(acc), .y(y_new)
    );

    // Register the result strobe; it follows in_valid by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Register the result data and hold it on idle clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= y_new;
    end
endmodule

// File: rtl/bpf_lag2_section_chk.sv
// Module: timing properties of the bandpass section's valid/data outputs.
// Assumes: bound to bpf_lag2_section; sees only its ports.
module bpf_lag2_section_chk #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> $stable(out_data));

    // R2
    strobe_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // in_data has no property of its own here; it stays in the port list so the bind matches.
    logic unused_in;
    assign unused_in = ^in_data;
endmodule

bind bpf_lag2_section bpf_lag2_section_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/bpf_lag2_section_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for the lag-two bandpass section. The driver queues the expected
// results; the monitor pops the queue just after each rising edge.
module bpf_lag2_section_bench;
    localparam int IN_W  = 16;
    localparam int OUT_W = 16;
    localparam int YMAX  = 32767;
    localparam int YMIN  = -32768;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    string tag_q[$];
    int last_out = 0;
    int peak_abs = 0;
    int mx1, mx2, my1, my2;

    always #2 clk = ~clk;

    bpf_lag2_section #(.IN_W(IN_W), .OUT_W(OUT_W), .GUARD(2)) u_bpf_lag2_section (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of the recurrence, from the requirements.
    function automatic int model(input int x);
        int s;
        s = x - mx2 - ((my2 + 2) >>> 2);
        if (s > YMAX) s = YMAX;
        if (s < YMIN) s = YMIN;
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = s;
        return s;
    endfunction

    task automatic send(input int x, input string tag);
        @(negedge clk);
        exp_q.push_back(model(x));
        tag_q.push_back(tag);
        in_valid = 1'b1;
        in_data  = IN_W'(x);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Idle clocks: no result may appear and the held data may not move (R4).
    task automatic idle(input int n);
        int held;
        held = $signed(out_data);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R4 idle valid", int'(out_valid), 0);
            check("R4 idle hold", $signed(out_data), held);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", $signed(out_data), 0);
        rst_n = 1'b1;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    // Monitor: compare each result against the queue head.
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected result", 1, 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, $signed(out_data), e);
                last_out = $signed(out_data);
                if (t == "R9" && (last_out > peak_abs || -last_out > peak_abs))
                    peak_abs = (last_out < 0) ? -last_out : last_out;
            end
        end
    end

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int imp [15] = '{1024, 0, -1280, 0, 320, 0, -80, 0, 20, 0, -5, 0, 1, 0, 0};
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        do_reset();
        // R1: cleared taps, so the first sample comes out unchanged
        send(777, "R1");
        idle(2);
        send(-300, "R3");
        send(5000, "R3");
        send(-12000, "R3");
        send(31, "R3");
        idle(5);
        send(4321, "R4");
        send(-1, "R3");
        // R8 impulse, checked against fixed values as well as the model
        do_reset();
        for (int i = 0; i < 15; i++) begin
            send((i == 0) ? 1024 : 0, "R8");
            @(posedge clk); #1;
            check("R8 impulse", last_out, imp[i]);
        end
        // R7 DC decays to zero
        do_reset();
        for (int i = 0; i < 20; i++) send(200, "R7");
        @(posedge clk); #1;
        check("R7 dc settled", last_out, 0);
        // R5 positive clamp
        do_reset();
        send(-32768, "R6"); send(0, "R3"); send(32767, "R5");
        @(posedge clk); #1;
        check("R5 clamp high", last_out, 32767);
        // R6 negative clamp
        do_reset();
        send(32767, "R5"); send(0, "R3"); send(-32768, "R6");
        @(posedge clk); #1;
        check("R6 clamp low", last_out, -32768);
        // R9 quarter-rate tone gain
        do_reset();
        for (int i = 0; i < 40; i++) begin
            if (i == 24) peak_abs = 0;
            send((i % 4 == 0) ? 1000 : ((i % 4 == 2) ? -1000 : 0),
                 (i < 24) ? "R3" : "R9");
        end
        @(posedge clk); #1;
        check("R9 peak above 2A", int'(peak_abs > 2000), 1);
        idle(3);
        check("R2 queue drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule